// File: doc/BRIEF.md
# Non-Volatile Byte Memory Write Sequencer

This block fronts a byte-wide non-volatile data store with a small register file that the processor core writes through a single register port. Reads are immediate: a read strobe loads the addressed byte into the data register while a stall output holds the core off for a few cycles. Writes are guarded. The core must first set an arming bit, and then issue the write strobe within a short window. A guarded write then runs for a long, parameterised programming time, and a busy bit stays high for that whole time.

When a write finishes, the block raises a ready interrupt. This interrupt is a level and not a pulse. It stays asserted as long as the memory is idle, the interrupt enable is set, and no read strobe has withdrawn it. Write strobes that arrive while a write is still running are dropped. Locations that have never been written return the erased value 0xFF. The storage is modelled as a synchronous RAM with one valid flag per word.

Top module: `eep_seq_ctrl`

## Requirements
- R1: Writing the control register (select code 0) with bit 2 set arms the block, and bit 2 of `ctrl_o` reads 1. A write strobe captured 1 to 4 clock edges after the arming write is accepted. When no write starts, the arming bit clears by itself on the 4th edge, and a strobe captured on the 5th edge or later does nothing.
- R2: Register select codes are 0 = control, 1 = address low, 2 = address high, 3 = data. A control write with bit 1 set while armed and idle stores the data register at the current address. Without arming, nothing is stored and `ctrl_o` bit 1 stays 0.
- R3: `ctrl_o` bit 1 (busy) reads 1 from the clock edge that accepts a write until exactly PROG_CYCLES edges later, and then returns to 0.
- R4: A write strobe issued while busy is ignored and leaves the memory unchanged, even if the block is armed.
- R5: `irq_o` is a level equal to ready AND enable, where the enable is control bit 3 (also `ctrl_o` bit 3). Ready is 1 after reset, 0 while a write runs, and 1 again when the write completes. The interrupt follows the enable bit in both directions.
- R6: A control write with bit 0 set, while idle, withdraws ready so that `irq_o` falls on that edge. The addressed byte appears on `data_o` one edge later, and `stall_o` is high for exactly 4 cycles.
- R7: An accepted write start drives `stall_o` high for exactly 2 cycles.
- R8: A location never written since reset reads 0xFF.
- R9: The word address is the address-low byte joined to the two least significant bits of address-high. The upper address-high bits are ignored.
- R10: After reset, `ctrl_o`, `data_o`, `irq_o` and `stall_o` are all 0.
- R11: A read strobe issued while busy is ignored: `data_o` keeps its value and `stall_o` stays low.
- R12: A single control write that sets both bit 2 and bit 1 while not already armed only arms the block. It does not start a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe from the core |
| reg_sel_i | input | 2 | Register select (0 control, 1 addr low, 2 addr high, 3 data) |
| reg_wdata_i | input | 8 | Register write data |
| ctrl_o | output | 4 | Control readback: {irq enable, armed, busy, 0} |
| data_o | output | 8 | Data register |
| irq_o | output | 1 | Level ready interrupt |
| stall_o | output | 1 | Core stall request |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is a write strobe on the same edge that the arming window expires. The bench sweeps the strobe distance from 1 to 6 edges after arming. At each distance it judges the busy bit and a later read of the target word against a window of four. The second pair is a read or write strobe that arrives while a write is running. It is provoked by issuing both inside the programming time. The bench then checks that the data register, the stall output and the untouched word are all unchanged.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_ADDR_HI = 2'd2,
        SEL_DATA    = 2'd3
    } reg_sel_e;

    // control register bit positions (decoded by the core's driver)
    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_ARM = 2;
    localparam int CB_RIE = 3;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/eep_unlock.sv
module eep_unlock #(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic take_i,
    output logic arm_o
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    typedef struct packed {
        logic          arm;
        logic [CW-1:0] cnt;
    } unlock_t;

    unlock_t q, d;

    always_comb begin
        d = q;
        if (take_i) begin
            d.arm = 1'b0;
        end else if (set_i) begin
            d.arm = 1'b1;
            d.cnt = CW'(WIN_CYCLES);
        end else if (q.arm) begin
            if (q.cnt == CW'(1)) begin
                d.arm = 1'b0;
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign arm_o = q.arm;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int PROG_CYCLES = 54400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CW'(PROG_CYCLES);
        end else if (q.busy) begin
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign done_o = q.busy && (q.cnt == CW'(1));

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int          ADDR_W = 10,
    parameter int          DATA_W = 8,
    parameter logic [7:0]  ERASED = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0]  vld;
        logic [DATA_W-1:0] rdata;
    } store_t;

    store_t q, d;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (we_i) begin
            d.vld[addr_i] = 1'b1;
        end
        if (re_i) begin
            d.rdata = q.vld[addr_i] ? mem[addr_i] : DATA_W'(ERASED);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = q.rdata;

endmodule

// File: rtl/eep_seq_ctrl.sv
module eep_seq_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PROG_CYCLES = 54400,
    parameter int WIN_CYCLES  = 4,
    parameter int RD_STALL    = 4,
    parameter int WR_STALL    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [3:0]        ctrl_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              irq_o,
    output logic              stall_o
);
    localparam int HI_W      = ADDR_W - BYTE_W;
    localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int STALL_W   = $clog2(STALL_MAX + 1);

    typedef struct packed {
        logic               rie;
        logic               rdy;
        logic [BYTE_W-1:0]  addr_lo;
        logic [HI_W-1:0]    addr_hi;
        logic [BYTE_W-1:0]  data;
        logic               rd_pend;
        logic [STALL_W-1:0] stall_cnt;
    } ctl_t;

    ctl_t q, d;

    logic              ctrl_wr;
    logic              arm_set;
    logic              armed;
    logic              busy;
    logic              done;
    logic              store_we;
    logic              store_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] store_rdata;

    assign ctrl_wr  = reg_we_i && (reg_sel_i == SEL_CTRL);
    assign arm_set  = ctrl_wr && reg_wdata_i[CB_ARM];
    assign store_we = ctrl_wr && reg_wdata_i[CB_WR] && armed && !busy;
    assign store_re = ctrl_wr && reg_wdata_i[CB_RD] && !busy && !store_we;
    assign mem_addr = {q.addr_hi, q.addr_lo};

    eep_unlock #(.WIN_CYCLES(WIN_CYCLES)) i_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (arm_set),
        .take_i (store_we),
        .arm_o  (armed)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (store_we),
        .busy_o  (busy),
        .done_o  (done)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .re_i    (store_re),
        .addr_i  (mem_addr),
        .wdata_i (q.data),
        .rdata_o (store_rdata)
    );

    always_comb begin
        d = q;
        if (reg_we_i) begin
            case (reg_sel_i)
                SEL_CTRL:    d.rie     = reg_wdata_i[CB_RIE];
                SEL_ADDR_LO: d.addr_lo = reg_wdata_i;
                SEL_ADDR_HI: d.addr_hi = reg_wdata_i[HI_W-1:0];
                default:     d.data    = reg_wdata_i;
            endcase
        end
        // read result lands one edge after the strobe
        if (q.rd_pend) begin
            d.data = store_rdata;
        end
        d.rd_pend = store_re;

        if (store_we) begin
            d.rdy = 1'b0;
        end else if (done) begin
            d.rdy = 1'b1;
        end else if (store_re) begin
            d.rdy = 1'b0;
        end

        if (store_re) begin
            d.stall_cnt = STALL_W'(RD_STALL);
        end else if (store_we) begin
            d.stall_cnt = STALL_W'(WR_STALL);
        end else if (q.stall_cnt != '0) begin
            d.stall_cnt = q.stall_cnt - STALL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.rdy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ctrl_o  = {q.rie, armed, busy, 1'b0};
    assign data_o  = q.data;
    assign irq_o   = q.rdy && q.rie;
    assign stall_o = (q.stall_cnt != '0);

endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk #(
    parameter int PROG_CYCLES = 54400,
    parameter int WIN_CYCLES  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we_i,
    input logic [1:0] reg_sel_i,
    input logic [7:0] reg_wdata_i,
    input logic [3:0] ctrl_o,
    input logic       irq_o,
    input logic       stall_o,
    input logic       store_we
);
    logic [31:0] arm_age;
    logic [31:0] busy_age;
    logic        ctl_wr;
    logic        rd_take;

    assign ctl_wr  = reg_we_i && (reg_sel_i == 2'd0);
    assign rd_take = ctl_wr && reg_wdata_i[0] && !ctrl_o[1]
                     && !(reg_wdata_i[1] && ctrl_o[2]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_age  <= 32'(WIN_CYCLES + 2);
            busy_age <= '0;
        end else begin
            if (ctl_wr && reg_wdata_i[2]) begin
                arm_age <= '0;
            end else if (arm_age < 32'(WIN_CYCLES + 2)) begin
                arm_age <= arm_age + 32'd1;
            end
            busy_age <= ctrl_o[1] ? busy_age + 32'd1 : '0;
        end
    end

    AST_ARM_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_age > 32'(WIN_CYCLES)) |-> !ctrl_o[2]); // R1
    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> ctrl_o[2]); // R2
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[1] |-> (busy_age < 32'(PROG_CYCLES))); // R3
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_o[1]) |-> ($past(busy_age) == 32'(PROG_CYCLES - 1))); // R3
    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> !ctrl_o[1]); // R4
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!ctrl_o[1] && ctrl_o[3])); // R5
    AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> (stall_o && !irq_o)); // R6
    AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |=> (stall_o && ctrl_o[1])); // R7

endmodule

bind eep_seq_ctrl eep_seq_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .WIN_CYCLES  (WIN_CYCLES)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .ctrl_o      (ctrl_o),
    .irq_o       (irq_o),
    .stall_o     (stall_o),
    .store_we    (store_we)
);

// File: tb/test_eep_seq_ctrl.sv
`timescale 1ns/1ps
module test_eep_seq_ctrl;
    localparam int ADDR_W = 10;
    localparam int PROG   = 20;
    localparam int DEPTH  = 1 << ADDR_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [3:0] ctrl;
    logic [7:0] data;
    logic       irq;
    logic       stall;

    int errors = 0;
    int checks = 0;
    logic [7:0] rie_b = 8'h00;

    always #2.5 clk = ~clk;

    eep_seq_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) i_eep_seq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .ctrl_o      (ctrl),
        .data_o      (data),
        .irq_o       (irq),
        .stall_o     (stall)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29) + ((a >> 8) * 7) + 3);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (ctrl[1]) @(negedge clk);
    endtask

    task automatic do_write(int a, logic [7:0] v);
        wr(2'd1, 8'(a));
        wr(2'd2, 8'hFC | 8'(a >> 8));
        wr(2'd3, v);
        wr(2'd0, 8'h04 | rie_b);
        wr(2'd0, 8'h02 | rie_b);
        wait_idle();
    endtask

    task automatic do_read(int a, output logic [7:0] v);
        wr(2'd1, 8'(a));
        wr(2'd2, 8'(a >> 8));
        wr(2'd0, 8'h01 | rie_b);
        idle(1);
        v = data;
        idle(3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] last;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        chk("R10 ctrl", int'(ctrl), 0);
        chk("R10 data", int'(data), 0);
        chk("R10 irq", int'(irq), 0);
        chk("R10 stall", int'(stall), 0);

        // R5 ready after reset follows enable both ways
        wr(2'd0, 8'h08);
        chk("R5 irq on enable", int'(irq), 1);
        wr(2'd0, 8'h00);
        chk("R5 irq off enable", int'(irq), 0);

        // R8 erased sweep
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, v);
            chk("R8 erased", int'(v), 8'hFF);
        end

        // R2 / R9 full write then read sweep (junk upper address-high bits on write)
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a));
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, v);
            chk("R2 R9 stored", int'(v), int'(pat(a)));
        end

        // R3 R7 R5 R6 timing of one write and one read
        rie_b = 8'h08;
        wr(2'd1, 8'd5); wr(2'd2, 8'd0); wr(2'd3, 8'h5A);
        wr(2'd0, 8'h0C);
        chk("R1 armed readback", int'(ctrl[2]), 1);
        wr(2'd0, 8'h0A);
        chk("R3 busy at start", int'(ctrl[1]), 1);
        chk("R7 stall cycle1", int'(stall), 1);
        chk("R5 irq low while busy", int'(irq), 0);
        idle(1);
        chk("R7 stall cycle2", int'(stall), 1);
        idle(1);
        chk("R7 stall released", int'(stall), 0);
        idle(PROG - 3);
        chk("R3 busy last cycle", int'(ctrl[1]), 1);
        idle(1);
        chk("R3 busy cleared", int'(ctrl[1]), 0);
        chk("R5 irq on completion", int'(irq), 1);
        wr(2'd0, 8'h09);
        chk("R6 read cancels irq", int'(irq), 0);
        chk("R6 stall start", int'(stall), 1);
        idle(1);
        chk("R6 read data", int'(data), 8'h5A);
        idle(2);
        chk("R6 stall cycle4", int'(stall), 1);
        idle(1);
        chk("R6 stall released", int'(stall), 0);
        wr(2'd0, 8'h08);
        chk("R6 irq stays cancelled", int'(irq), 0);

        // R1 window sweep on address 9
        last = pat(9);
        for (int dd = 1; dd <= 6; dd++) begin
            wr(2'd1, 8'd9); wr(2'd2, 8'd0); wr(2'd3, 8'(8'h30 + dd));
            wr(2'd0, 8'h04 | rie_b);
            idle(dd - 1);
            chk("R1 armed before strobe", int'(ctrl[2]), (dd <= 4) ? 1 : 0);
            wr(2'd0, 8'h02 | rie_b);
            chk("R1 R2 strobe accepted", int'(ctrl[1]), (dd <= 4) ? 1 : 0);
            if (dd <= 4) last = 8'(8'h30 + dd);
            wait_idle();
            idle(5);
            do_read(9, v);
            chk("R1 window content", int'(v), int'(last));
        end

        // R4 R11 strobes while busy
        wr(2'd1, 8'd12); wr(2'd2, 8'd0); wr(2'd3, 8'h77);
        wr(2'd0, 8'h04 | rie_b);
        wr(2'd0, 8'h02 | rie_b);
        wr(2'd1, 8'd13);
        wr(2'd3, 8'hEE);
        wr(2'd0, 8'h04 | rie_b);
        wr(2'd0, 8'h02 | rie_b);
        wr(2'd0, 8'h01 | rie_b);
        idle(1);
        chk("R11 data kept", int'(data), 8'hEE);
        chk("R11 no stall", int'(stall), 0);
        chk("R11 still busy", int'(ctrl[1]), 1);
        wait_idle();
        idle(5);
        do_read(13, v);
        chk("R4 dropped write", int'(v), int'(pat(13)));
        do_read(12, v);
        chk("R4 first write kept", int'(v), 8'h77);

        // R12 arm and strobe in one control write
        wr(2'd1, 8'd20); wr(2'd2, 8'd0); wr(2'd3, 8'h99);
        wr(2'd0, 8'h06 | rie_b);
        chk("R12 no start", int'(ctrl[1]), 0);
        chk("R12 armed only", int'(ctrl[2]), 1);
        idle(6);
        do_read(20, v);
        chk("R12 memory unchanged", int'(v), int'(pat(20)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule